// File: doc/BRIEF.md
# DMA Bus Access Filter with Open-Bus Latch

This block screens every byte transfer that the DMA engine issues before it reaches the address decoder. Two kinds of access are refused. The first is a transfer issued on the bus-A side that points into the page of bus-B peripheral registers. The second is any transfer, from either side, that points at the DMA controller's own channel and enable registers. A refused write is dropped: the target strobe never rises. A refused read is answered with the value last driven on the data bus.

That last value is held in an open-bus register. Every completed read that lands on a mapped target loads this register with the byte handed back to the DMA engine. This includes refused reads, which load the value they already returned. A read that finds no mapped target also returns the open-bus value and leaves the register unchanged.

Every access is sorted into one of four named verdicts: PASS, BLOCK_CROSS (a bus-A access into the bus-B page), BLOCK_SELF (an access to the DMA controller's own registers) and NO_TARGET (an unmapped read). A single `unique case` on the verdict drives all outputs. The filter on the strobes is purely combinational. The only sequential element is the open-bus register. It has two transitions: LOAD on a read edge whose verdict is not NO_TARGET, and HOLD otherwise.

Top module: `dmaf_top`

## Requirements
- R1: After reset the open-bus register holds 0x00, so a refused read issued first returns 0x00.
- R2: With the bus-A selector high, an access whose bank is 0x00–0x3F or 0x80–0xBF and whose address bits [15:8] are 0x21 raises neither target strobe.
- R3: With the bus-B selector (from_bus_a low), an access to the 0x21 page passes, with its strobe forwarded in the same cycle.
- R4: An access from either side to offset 0x420B, to offset 0x420C, or to any offset from 0x4300 to 0x437F, in bank 0x00–0x3F or 0x80–0xBF, raises neither target strobe.
- R5: A refused read returns the current open-bus value.
- R6: A read with tgt_hit low returns the open-bus value, and the open-bus value is unchanged afterwards.
- R7: A read that passes with tgt_hit high returns tgt_rdata in the same cycle, and the open-bus register holds that byte after the next rising clock edge.
- R8: In banks 0x40–0x7F and 0xC0–0xFF no access is refused, whatever its offset or side.
- R9: Offsets next to the refused ones (for example 0x420A, 0x420D, 0x4380, 0x2000, 0x22FF) pass in mapped banks.
- R10: tgt_wdata always equals dma_wdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the open-bus register updates on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_addr | input | 24 | Byte address: bank in [23:16], offset in [15:0] |
| from_bus_a | input | 1 | 1 when the transfer is issued on the bus-A side |
| dma_rd | input | 1 | Read request from the DMA engine |
| dma_wr | input | 1 | Write request from the DMA engine |
| dma_wdata | input | 8 | Write data |
| tgt_rdata | input | 8 | Read data from the decoded target |
| tgt_hit | input | 1 | 1 when the decoder maps the address to a target |
| tgt_rd | output | 1 | Read strobe forwarded to the target |
| tgt_wr | output | 1 | Write strobe forwarded to the target |
| tgt_wdata | output | 8 | Write data forwarded to the target |
| dma_rdata | output | 8 | Byte returned to the DMA engine |

## Verification
The open-bus register is the only state in the block. If it is wrong, the error appears at the ports on the next refused or unmapped read: that read returns a stale or corrupted byte in the same cycle it is issued. The sweep mixes passing, refused and unmapped reads back to back, so a missed LOAD, or a spurious LOAD on an unmapped read, shows within one access. A decode error appears immediately as a strobe that is forwarded or dropped when it should not be.

// File: rtl/dmaf_pkg.sv
package dmaf_pkg;

    typedef enum logic [1:0] {
        ACC_PASS        = 2'd0,
        ACC_BLOCK_CROSS = 2'd1,
        ACC_BLOCK_SELF  = 2'd2,
        ACC_NO_TARGET   = 2'd3
    } acc_verdict_e;

    typedef enum logic {
        OB_HOLD = 1'b0,
        OB_LOAD = 1'b1
    } ob_action_e;

endpackage

// File: rtl/dmaf_window_dec.sv
module dmaf_window_dec #(
    parameter int          ADDR_W        = 24,
    parameter logic [7:0]  CROSS_PAGE    = 8'h21,
    parameter logic [15:0] SELF_REG_A    = 16'h420B,
    parameter logic [15:0] SELF_REG_B    = 16'h420C,
    parameter logic [15:0] SELF_BLK_LO   = 16'h4300,
    parameter logic [15:0] SELF_BLK_HI   = 16'h437F
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              bank_has_regs,
    output logic              in_cross_page,
    output logic              in_self_regs
);

    localparam int BANK_LSB = ADDR_W - 8;

    logic [7:0]  bank;
    logic [15:0] offs;

    always_comb begin
        bank = addr[ADDR_W-1:BANK_LSB];
        offs = addr[15:0];
    end

    always_comb begin
        // register windows live in banks whose bit 6 is clear
        bank_has_regs = (bank[6] == 1'b0);
        in_cross_page = bank_has_regs && (offs[15:8] == CROSS_PAGE);
        in_self_regs  = bank_has_regs &&
                        ((offs == SELF_REG_A) ||
                         (offs == SELF_REG_B) ||
                         ((offs >= SELF_BLK_LO) && (offs <= SELF_BLK_HI)));
    end

endmodule

// File: rtl/dmaf_verdict.sv
module dmaf_verdict
    import dmaf_pkg::*;
(
    input  logic         from_bus_a,
    input  logic         in_cross_page,
    input  logic         in_self_regs,
    input  logic         tgt_hit,
    output acc_verdict_e verdict
);

    always_comb begin
        if (from_bus_a && in_cross_page) begin
            verdict = ACC_BLOCK_CROSS;
        end else if (in_self_regs) begin
            verdict = ACC_BLOCK_SELF;
        end else if (!tgt_hit) begin
            verdict = ACC_NO_TARGET;
        end else begin
            verdict = ACC_PASS;
        end
    end

endmodule

// File: rtl/dmaf_openbus.sv
module dmaf_openbus
    import dmaf_pkg::*;
#(
    parameter int          DATA_W    = 8,
    parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ob_action_e        action,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] bus_val
);

    logic [DATA_W-1:0] bus_nxt;

    always_comb begin
        unique case (action)
            OB_LOAD: bus_nxt = load_val;
            OB_HOLD: bus_nxt = bus_val;
            default: bus_nxt = bus_val;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_val <= RESET_VAL;
        end else begin
            bus_val <= bus_nxt;
        end
    end

endmodule

// File: rtl/dmaf_top.sv
module dmaf_top
    import dmaf_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] dma_addr,
    input  logic              from_bus_a,
    input  logic              dma_rd,
    input  logic              dma_wr,
    input  logic [DATA_W-1:0] dma_wdata,
    input  logic [DATA_W-1:0] tgt_rdata,
    input  logic              tgt_hit,
    output logic              tgt_rd,
    output logic              tgt_wr,
    output logic [DATA_W-1:0] tgt_wdata,
    output logic [DATA_W-1:0] dma_rdata
);

    logic              bank_has_regs;
    logic              in_cross_page;
    logic              in_self_regs;
    acc_verdict_e      verdict;
    ob_action_e        ob_action;
    logic [DATA_W-1:0] ob_val;

    dmaf_window_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr          (dma_addr),
        .bank_has_regs (bank_has_regs),
        .in_cross_page (in_cross_page),
        .in_self_regs  (in_self_regs)
    );

    dmaf_verdict u_ver (
        .from_bus_a    (from_bus_a),
        .in_cross_page (in_cross_page),
        .in_self_regs  (in_self_regs),
        .tgt_hit       (tgt_hit),
        .verdict       (verdict)
    );

    // output process: all port values come from the verdict
    always_comb begin
        tgt_wdata = dma_wdata;
        unique case (verdict)
            ACC_PASS: begin
                tgt_rd    = dma_rd;
                tgt_wr    = dma_wr;
                dma_rdata = tgt_rdata;
                ob_action = dma_rd ? OB_LOAD : OB_HOLD;
            end
            ACC_BLOCK_CROSS, ACC_BLOCK_SELF: begin
                tgt_rd    = 1'b0;
                tgt_wr    = 1'b0;
                dma_rdata = ob_val;
                ob_action = dma_rd ? OB_LOAD : OB_HOLD;
            end
            ACC_NO_TARGET: begin
                tgt_rd    = dma_rd;
                tgt_wr    = dma_wr;
                dma_rdata = ob_val;
                ob_action = OB_HOLD;
            end
            default: begin
                tgt_rd    = 1'b0;
                tgt_wr    = 1'b0;
                dma_rdata = ob_val;
                ob_action = OB_HOLD;
            end
        endcase
    end

    dmaf_openbus #(.DATA_W(DATA_W)) u_ob (
        .clk      (clk),
        .rst_n    (rst_n),
        .action   (ob_action),
        .load_val (dma_rdata),
        .bus_val  (ob_val)
    );

    logic unused_bank;
    assign unused_bank = bank_has_regs;

endmodule

// File: rtl/dmaf_checker.sv
module dmaf_checker #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] dma_addr,
    input logic              from_bus_a,
    input logic              dma_rd,
    input logic              dma_wr,
    input logic [DATA_W-1:0] dma_wdata,
    input logic [DATA_W-1:0] tgt_rdata,
    input logic              tgt_hit,
    input logic              tgt_rd,
    input logic              tgt_wr,
    input logic [DATA_W-1:0] tgt_wdata,
    input logic [DATA_W-1:0] dma_rdata
);

    localparam int BANK_MSB = ADDR_W - 1;
    localparam int BANK_B6  = ADDR_W - 2;

    assert_cross_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (from_bus_a && !dma_addr[BANK_B6] && dma_addr[15:8] == 8'h21)
            |-> (!tgt_rd && !tgt_wr));

    assert_self_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_addr[BANK_B6] && (dma_addr[15:0] == 16'h420B || dma_addr[15:0] == 16'h420C))
            |-> (!tgt_rd && !tgt_wr));

    assert_refused_repeats_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(dma_rd) && dma_rd && !tgt_rd)
            |-> (dma_rdata == $past(dma_rdata)));

    assert_pass_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_rd && tgt_rd && tgt_hit) |-> (dma_rdata == tgt_rdata));

    assert_upper_banks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_addr[BANK_B6]) |-> (tgt_rd == dma_rd && tgt_wr == dma_wr));

    assert_wdata_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_wdata == dma_wdata);

    logic unused_msb;
    assign unused_msb = dma_addr[BANK_MSB];

endmodule

bind dmaf_top dmaf_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dma_addr   (dma_addr),
    .from_bus_a (from_bus_a),
    .dma_rd     (dma_rd),
    .dma_wr     (dma_wr),
    .dma_wdata  (dma_wdata),
    .tgt_rdata  (tgt_rdata),
    .tgt_hit    (tgt_hit),
    .tgt_rd     (tgt_rd),
    .tgt_wr     (tgt_wr),
    .tgt_wdata  (tgt_wdata),
    .dma_rdata  (dma_rdata)
);

// File: tb/sim_dmaf_top.sv
`timescale 1ns/1ps
module sim_dmaf_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] dma_addr = '0;
    logic        from_bus_a = 1'b0;
    logic        dma_rd = 1'b0;
    logic        dma_wr = 1'b0;
    logic [7:0]  dma_wdata = '0;
    logic [7:0]  tgt_rdata = '0;
    logic        tgt_hit = 1'b0;
    logic        tgt_rd;
    logic        tgt_wr;
    logic [7:0]  tgt_wdata;
    logic [7:0]  dma_rdata;

    int checks = 0;
    int errors = 0;
    logic [7:0] ob_model = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmaf_top u0 (
        .clk(clk), .rst_n(rst_n), .dma_addr(dma_addr), .from_bus_a(from_bus_a),
        .dma_rd(dma_rd), .dma_wr(dma_wr), .dma_wdata(dma_wdata),
        .tgt_rdata(tgt_rdata), .tgt_hit(tgt_hit), .tgt_rd(tgt_rd),
        .tgt_wr(tgt_wr), .tgt_wdata(tgt_wdata), .dma_rdata(dma_rdata)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s addr=%06h busA=%0d actual=%02h expected=%02h",
                     req, dma_addr, from_bus_a, act, exp);
        end
    endtask

    function automatic string strobe_tag(input logic [7:0] bank, input logic [15:0] offs,
                                         input logic busa);
        logic mapped;
        mapped = (bank < 8'h40) || (bank >= 8'h80 && bank < 8'hC0);
        if (!mapped) return "R8";
        if (busa && offs[15:8] == 8'h21) return "R2";
        if (offs == 16'h420B || offs == 16'h420C || (offs >= 16'h4300 && offs <= 16'h437F))
            return "R4";
        if (offs[15:8] == 8'h21) return "R3";
        return "R9";
    endfunction

    // one access: drive after negedge, sample mid-low-phase, commit on posedge
    task automatic access(input logic [7:0] bank, input logic [15:0] offs, input logic busa,
                          input logic is_rd, input logic hit, input logic [7:0] data);
        string tag;
        logic  refused;
        logic [7:0] exp_rd;
        @(negedge clk);
        dma_addr   = {bank, offs};
        from_bus_a = busa;
        dma_rd     = is_rd;
        dma_wr     = !is_rd;
        tgt_hit    = hit;
        tgt_rdata  = data;
        dma_wdata  = ~data;
        tag = strobe_tag(bank, offs, busa);
        refused = (tag == "R2") || (tag == "R4");
        #1;
        check(tag, {7'd0, tgt_rd}, {7'd0, is_rd && !refused});
        check(tag, {7'd0, tgt_wr}, {7'd0, !is_rd && !refused});
        if (is_rd) begin
            exp_rd = (refused || !hit) ? ob_model : data;
            check(refused ? "R5" : (!hit ? "R6" : "R7"), dma_rdata, exp_rd);
            if (refused || hit) ob_model = exp_rd;
        end else begin
            check("R10", tgt_wdata, ~data);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] banks [8];
        logic [7:0] lows  [6];
        logic [7:0] cnt;
        banks = '{8'h00, 8'h3F, 8'h40, 8'h7F, 8'h80, 8'hBF, 8'hC0, 8'hFF};
        lows  = '{8'h00, 8'h0B, 8'h0C, 8'h7F, 8'h80, 8'hFF};
        cnt = 8'h5A;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: first access is a refused read, must return reset value 0x00
        access(8'h00, 16'h420B, 1'b0, 1'b1, 1'b1, 8'hEE);
        check("R1", dma_rdata, 8'h00);
        // R6: unmapped read leaves open bus alone; R7 load then observe
        access(8'h10, 16'h8000, 1'b0, 1'b1, 1'b1, 8'hA5);
        access(8'h10, 16'h8001, 1'b0, 1'b1, 1'b0, 8'h3C);
        access(8'h00, 16'h4300, 1'b1, 1'b1, 1'b1, 8'h11);
        check("R6", dma_rdata, 8'hA5);
        // R9 explicit neighbours
        access(8'h80, 16'h420A, 1'b1, 1'b1, 1'b1, 8'h21);
        access(8'h80, 16'h420D, 1'b1, 1'b1, 1'b1, 8'h22);
        access(8'h80, 16'h4380, 1'b1, 1'b1, 1'b1, 8'h23);
        access(8'h80, 16'h22FF, 1'b1, 1'b1, 1'b1, 8'h24);
        // sweep
        for (int b = 0; b < 8; b++) begin
            for (int p = 0; p < 256; p++) begin
                for (int l = 0; l < 6; l++) begin
                    for (int s = 0; s < 2; s++) begin
                        for (int r = 0; r < 2; r++) begin
                            cnt = cnt + 8'd37;
                            access(banks[b], {p[7:0], lows[l]}, s[0], r[0],
                                   (cnt[2:0] != 3'd0), cnt);
                        end
                    end
                end
            end
        end
        @(negedge clk);
        dma_rd = 1'b0;
        dma_wr = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule